// File: doc/BRIEF.md
# Two-Slot Execution List Scheduler

This block keeps the submission bookkeeping for one command engine that runs work from a two-entry queue. Each queue entry holds a pair of context descriptors. A descriptor has an identifier, a base address and a valid flag. The requester issues two kinds of request. A schedule-in request presents a new descriptor pair. A schedule-out request names the context that has just finished. The block records which slot is running, whether a second slot waits as pending, and which context of the running pair is current.

From that state the block drives a packed status word. For every transition it also emits one or two context-status events on a valid/ready channel, and a separate status-buffer writer consumes them. Two descriptors are treated as the same context only when both the identifier and the base address match. Identity decides between three outcomes: an element switch inside a pair, an immediate lite restore with preemption, or queuing the new pair as pending.

Requests are taken only while no event is waiting on the output channel. A request the block cannot honour produces a one-cycle error pulse and leaves the state untouched.

Top module: `exl_sched`

## Requirements
- R1: Two descriptors are the same context only if both identifier and base address are equal. A schedule-out naming a matching identifier with a different base is treated as not current.
- R2: A schedule-in while idle writes the pair into the slot named by the status write pointer. That slot becomes running with its first context current and nothing pending. One event is emitted with flags idle-to-active (bit 0), identifier 0 and irq set.
- R3: A schedule-in while running makes the new pair running at once when either of two conditions holds. Condition one: the running second context is valid, equals the new first context, and the running first context is not current. Condition two: the running second context is invalid and the running first context equals the new first context. The new first context becomes current. One event is emitted with preempted (bit 1) and lite-restore (bit 5), the new first identifier, and irq set.
- R4: Any other schedule-in while running stores the pair as pending, sets the queue-full status bit and emits no event.
- R5: A schedule-in while a pending pair exists pulses err for one cycle and changes nothing.
- R6: A schedule-out of the current context moves current to the second context when the second context is valid and the finished context equals the first. One event is emitted with context-complete (bit 4) and element-switch (bit 2), the finished identifier, and irq set.
- R7: A schedule-out that finishes the last valid element emits context-complete plus active-to-idle (bit 3) with the finished identifier. With no pending pair, the block goes idle and irq is set on that event. With a pending pair, the pending pair becomes running with its first context current. The first event then carries irq clear and is followed by an idle-to-active event with identifier 0 and irq set.
- R8: A schedule-out while idle, or naming a context other than the current one, pulses err and changes nothing.
- R9: Status layout is as follows. Bit 0 is the current pointer, equal to the running slot index. Bit 1 is the write pointer, its inverse. Bits 2 and 3 are valid and active for list 0, and bits 4 and 5 are valid and active for list 1; each pair is set when its slot is running. Bit 6 is queue-full. Bits 7 and up hold the current context identifier. When idle, the list bits and the identifier are 0 and both pointers keep their last values.
- R10: An event stays valid and stable until evt_ready is high at a clock edge. While any event is outstanding, req_ready is low and requests have no effect.
- R11: Schedule-in and schedule-out raised together pulse err and change nothing.
- R12: After reset the status word is 0, no event is valid, err is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sin_req | input | 1 | Schedule-in request |
| sin_c0_id | input | ID_W | New first context identifier |
| sin_c0_base | input | BASE_W | New first context base address |
| sin_c0_vld | input | 1 | New first context valid |
| sin_c1_id | input | ID_W | New second context identifier |
| sin_c1_base | input | BASE_W | New second context base address |
| sin_c1_vld | input | 1 | New second context valid |
| sout_req | input | 1 | Schedule-out request |
| sout_id | input | ID_W | Finished context identifier |
| sout_base | input | BASE_W | Finished context base address |
| req_ready | output | 1 | High when a request will be taken |
| status | output | ID_W+7 | Packed status word |
| evt_valid | output | 1 | Event valid |
| evt_ready | input | 1 | Event consumer ready |
| evt_flags | output | 6 | Event flag bits |
| evt_id | output | ID_W | Event context identifier |
| evt_irq | output | 1 | Event requests an interrupt |
| err | output | 1 | One-cycle illegal request pulse |

## Verification
The bench builds the block with ID_W = 8 and BASE_W = 4. The short base field makes it cheap to form two descriptors that share an identifier but differ in base, which exercises the identity rule directly. A 15-bit status word keeps every flag and pointer readable in a single compare. With these widths the stimulus table can walk both slot indices through all transitions: idle start, both lite-restore conditions, pending and refusal, element switch, and promotion from pending. A held-low ready then exposes the stall behaviour.

// File: rtl/exl_pkg.sv
package exl_pkg;
  localparam int NSLOT = 2;
  localparam int EVF_W = 6;
  localparam int EVB_I2A  = 0;
  localparam int EVB_PRE  = 1;
  localparam int EVB_ESW  = 2;
  localparam int EVB_A2I  = 3;
  localparam int EVB_CC   = 4;
  localparam int EVB_LITE = 5;
  localparam int STB_CUR = 0;
  localparam int STB_WR  = 1;
  localparam int STB_L0V = 2;
  localparam int STB_L0A = 3;
  localparam int STB_L1V = 4;
  localparam int STB_L1A = 5;
  localparam int STB_QF  = 6;
  localparam int STB_ID  = 7;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_IN = 2'd1, OP_OUT = 2'd2, OP_BAD = 2'd3} op_e;
endpackage

// File: rtl/exl_slot_bank.sv
module exl_slot_bank #(
  parameter int DW = 13
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           wr_idx,
  input  logic [DW-1:0]                  wr_c0,
  input  logic [DW-1:0]                  wr_c1,
  output logic [exl_pkg::NSLOT-1:0][DW-1:0] rd_c0,
  output logic [exl_pkg::NSLOT-1:0][DW-1:0] rd_c1
);
  import exl_pkg::*;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [DW-1:0] c0_q, c1_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        c0_q <= '0;
        c1_q <= '0;
      end else if (wr_en && (wr_idx == s[0])) begin
        c0_q <= wr_c0;
        c1_q <= wr_c1;
      end
    end
    assign rd_c0[s] = c0_q;
    assign rd_c1[s] = c1_q;
  end
endmodule

// File: rtl/exl_ctrl.sv
module exl_ctrl #(
  parameter int ID_W   = 16,
  parameter int BASE_W = 20,
  localparam int DW    = ID_W + BASE_W + 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              acc_en,
  input  exl_pkg::op_e                      op,
  input  logic [DW-1:0]                     new0,
  input  logic [DW-2:0]                     fin,
  input  logic                              wr_ptr,
  input  logic [exl_pkg::NSLOT-1:0][DW-1:0] slot_c0,
  input  logic [exl_pkg::NSLOT-1:0][DW-1:0] slot_c1,
  output logic                              bank_we,
  output logic                              nxt_run_vld,
  output logic                              nxt_run_idx,
  output logic                              nxt_pend_vld,
  output logic [ID_W-1:0]                   nxt_cur_id,
  output logic                              ev_push,
  output logic                              ev_two,
  output logic [exl_pkg::EVF_W-1:0]         ev_flags,
  output logic [ID_W-1:0]                   ev_id,
  output logic                              ev_irq,
  output logic                              err_q
);
  import exl_pkg::*;

  logic run_vld, run_idx, pend_vld, cur_sel;
  logic nxt_cur_sel, err_n;
  logic [DW-1:0] rc0, rc1, pc0, cur_d;

  function automatic logic same_ctx(input logic [DW-2:0] a, input logic [DW-2:0] b);
    return a == b;
  endfunction

  assign rc0   = slot_c0[run_idx];
  assign rc1   = slot_c1[run_idx];
  assign pc0   = slot_c0[~run_idx];
  assign cur_d = cur_sel ? rc1 : rc0;

  logic rc1_vld, lite_a, lite_b, fin_cur, fin_r0, fin_r1;
  assign rc1_vld = rc1[DW-1];
  assign lite_a  = rc1_vld && same_ctx(rc1[DW-2:0], new0[DW-2:0]) && !same_ctx(rc0[DW-2:0], cur_d[DW-2:0]);
  assign lite_b  = !rc1_vld && same_ctx(rc0[DW-2:0], new0[DW-2:0]);
  assign fin_cur = same_ctx(fin, cur_d[DW-2:0]);
  assign fin_r0  = same_ctx(fin, rc0[DW-2:0]);
  assign fin_r1  = same_ctx(fin, rc1[DW-2:0]);

  always_comb begin
    nxt_run_vld  = run_vld;
    nxt_run_idx  = run_idx;
    nxt_pend_vld = pend_vld;
    nxt_cur_sel  = cur_sel;
    nxt_cur_id   = run_vld ? cur_d[ID_W-1:0] : '0;
    bank_we      = 1'b0;
    ev_push      = 1'b0;
    ev_two       = 1'b0;
    ev_flags     = '0;
    ev_id        = '0;
    ev_irq       = 1'b0;
    err_n        = 1'b0;
    if (acc_en) begin
      unique case (op)
        OP_IN: begin
          if (pend_vld) begin
            err_n = 1'b1;
          end else begin
            bank_we = 1'b1;
            if (!run_vld || lite_a || lite_b) begin
              nxt_run_vld  = 1'b1;
              nxt_run_idx  = wr_ptr;
              nxt_pend_vld = 1'b0;
              nxt_cur_sel  = 1'b0;
              nxt_cur_id   = new0[ID_W-1:0];
              ev_push      = 1'b1;
              ev_irq       = 1'b1;
              if (!run_vld) begin
                ev_flags[EVB_I2A] = 1'b1;
              end else begin
                ev_flags[EVB_PRE]  = 1'b1;
                ev_flags[EVB_LITE] = 1'b1;
                ev_id              = new0[ID_W-1:0];
              end
            end else begin
              nxt_pend_vld = 1'b1;
            end
          end
        end
        OP_OUT: begin
          if (!run_vld || !fin_cur) begin
            err_n = 1'b1;
          end else if (rc1_vld && fin_r0) begin
            nxt_cur_sel       = 1'b1;
            nxt_cur_id        = rc1[ID_W-1:0];
            ev_push           = 1'b1;
            ev_irq            = 1'b1;
            ev_flags[EVB_CC]  = 1'b1;
            ev_flags[EVB_ESW] = 1'b1;
            ev_id             = fin[ID_W-1:0];
          end else if ((!rc1_vld && fin_r0) || (rc1_vld && fin_r1)) begin
            ev_push           = 1'b1;
            ev_flags[EVB_CC]  = 1'b1;
            ev_flags[EVB_A2I] = 1'b1;
            ev_id             = fin[ID_W-1:0];
            nxt_cur_sel       = 1'b0;
            if (pend_vld) begin
              nxt_run_idx  = ~run_idx;
              nxt_pend_vld = 1'b0;
              nxt_cur_id   = pc0[ID_W-1:0];
              ev_two       = 1'b1;
              ev_irq       = 1'b0;
            end else begin
              nxt_run_vld = 1'b0;
              nxt_cur_id  = '0;
              ev_irq      = 1'b1;
            end
          end else begin
            err_n = 1'b1;
          end
        end
        OP_BAD:  err_n = 1'b1;
        default: err_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_vld  <= 1'b0;
      run_idx  <= 1'b0;
      pend_vld <= 1'b0;
      cur_sel  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      run_vld  <= nxt_run_vld;
      run_idx  <= nxt_run_idx;
      pend_vld <= nxt_pend_vld;
      cur_sel  <= nxt_cur_sel;
      err_q    <= err_n;
    end
  end

  AST_PEND_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    pend_vld |-> run_vld); // R4
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ($stable(run_vld) && $stable(run_idx) && $stable(pend_vld) && $stable(cur_sel))); // R8
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> ($stable(run_vld) && $stable(run_idx) && $stable(pend_vld) && $stable(cur_sel))); // R10
endmodule

// File: rtl/exl_evt_q.sv
module exl_evt_q #(
  parameter int ID_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic                      two,
  input  logic [exl_pkg::EVF_W-1:0] flags_in,
  input  logic [ID_W-1:0]           id_in,
  input  logic                      irq_in,
  input  logic                      evt_ready,
  output logic                      evt_valid,
  output logic [exl_pkg::EVF_W-1:0] evt_flags,
  output logic [ID_W-1:0]           evt_id,
  output logic                      evt_irq
);
  import exl_pkg::*;

  logic hold2;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid <= 1'b0;
      evt_flags <= '0;
      evt_id    <= '0;
      evt_irq   <= 1'b0;
      hold2     <= 1'b0;
    end else if (push) begin
      evt_valid <= 1'b1;
      evt_flags <= flags_in;
      evt_id    <= id_in;
      evt_irq   <= irq_in;
      hold2     <= two;
    end else if (evt_valid && evt_ready) begin
      if (hold2) begin
        evt_flags          <= '0;
        evt_flags[EVB_I2A] <= 1'b1;
        evt_id             <= '0;
        evt_irq            <= 1'b1;
        hold2              <= 1'b0;
      end else begin
        evt_valid <= 1'b0;
      end
    end
  end

  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_flags) && $stable(evt_id) && $stable(evt_irq))); // R10
  AST_IRQ_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && hold2) |-> !evt_irq); // R7
endmodule

// File: rtl/exl_stat.sv
module exl_stat #(
  parameter int ID_W = 16,
  localparam int SW  = ID_W + 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            nxt_run_vld,
  input  logic            nxt_run_idx,
  input  logic            nxt_pend_vld,
  input  logic [ID_W-1:0] nxt_cur_id,
  output logic [SW-1:0]   status_q
);
  import exl_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
    end else begin
      if (nxt_run_vld) begin
        status_q[STB_CUR] <= nxt_run_idx;
        status_q[STB_WR]  <= ~nxt_run_idx;
      end
      status_q[STB_L0V] <= nxt_run_vld && !nxt_run_idx;
      status_q[STB_L0A] <= nxt_run_vld && !nxt_run_idx;
      status_q[STB_L1V] <= nxt_run_vld && nxt_run_idx;
      status_q[STB_L1A] <= nxt_run_vld && nxt_run_idx;
      status_q[STB_QF]  <= nxt_pend_vld;
      status_q[STB_ID +: ID_W] <= nxt_run_vld ? nxt_cur_id : '0;
    end
  end

  AST_ONE_LIST: assert property (@(posedge clk) disable iff (rst)
    !(status_q[STB_L0V] && status_q[STB_L1V])); // R9
  AST_PTR_INVERSE: assert property (@(posedge clk) disable iff (rst)
    (status_q[STB_L0V] || status_q[STB_L1V]) |-> (status_q[STB_CUR] != status_q[STB_WR])); // R9
endmodule

// File: rtl/exl_sched.sv
module exl_sched #(
  parameter int ID_W   = 16,
  parameter int BASE_W = 20,
  localparam int DW    = ID_W + BASE_W + 1,
  localparam int SW    = ID_W + 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sin_req,
  input  logic [ID_W-1:0]           sin_c0_id,
  input  logic [BASE_W-1:0]         sin_c0_base,
  input  logic                      sin_c0_vld,
  input  logic [ID_W-1:0]           sin_c1_id,
  input  logic [BASE_W-1:0]         sin_c1_base,
  input  logic                      sin_c1_vld,
  input  logic                      sout_req,
  input  logic [ID_W-1:0]           sout_id,
  input  logic [BASE_W-1:0]         sout_base,
  output logic                      req_ready,
  output logic [SW-1:0]             status,
  output logic                      evt_valid,
  input  logic                      evt_ready,
  output logic [exl_pkg::EVF_W-1:0] evt_flags,
  output logic [ID_W-1:0]           evt_id,
  output logic                      evt_irq,
  output logic                      err
);
  import exl_pkg::*;

  logic [DW-1:0] new0, new1;
  logic [DW-2:0] fin;
  logic [NSLOT-1:0][DW-1:0] slot_c0, slot_c1;
  logic acc_en, bank_we;
  logic nxt_run_vld, nxt_run_idx, nxt_pend_vld;
  logic [ID_W-1:0] nxt_cur_id;
  logic ev_push, ev_two, ev_irq;
  logic [EVF_W-1:0] ev_flags;
  logic [ID_W-1:0] ev_id;
  op_e op;

  assign new0      = {sin_c0_vld, sin_c0_base, sin_c0_id};
  assign new1      = {sin_c1_vld, sin_c1_base, sin_c1_id};
  assign fin       = {sout_base, sout_id};
  assign req_ready = !evt_valid;
  assign acc_en    = req_ready && (sin_req || sout_req);
  assign op        = op_e'({sout_req, sin_req});

  exl_slot_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(bank_we), .wr_idx(status[STB_WR]),
    .wr_c0(new0), .wr_c1(new1), .rd_c0(slot_c0), .rd_c1(slot_c1)
  );

  exl_ctrl #(.ID_W(ID_W), .BASE_W(BASE_W)) u_ctrl (
    .clk(clk), .rst(rst), .acc_en(acc_en), .op(op), .new0(new0), .fin(fin),
    .wr_ptr(status[STB_WR]), .slot_c0(slot_c0), .slot_c1(slot_c1),
    .bank_we(bank_we), .nxt_run_vld(nxt_run_vld), .nxt_run_idx(nxt_run_idx),
    .nxt_pend_vld(nxt_pend_vld), .nxt_cur_id(nxt_cur_id),
    .ev_push(ev_push), .ev_two(ev_two), .ev_flags(ev_flags), .ev_id(ev_id),
    .ev_irq(ev_irq), .err_q(err)
  );

  exl_evt_q #(.ID_W(ID_W)) u_evt (
    .clk(clk), .rst(rst), .push(ev_push), .two(ev_two), .flags_in(ev_flags),
    .id_in(ev_id), .irq_in(ev_irq), .evt_ready(evt_ready), .evt_valid(evt_valid),
    .evt_flags(evt_flags), .evt_id(evt_id), .evt_irq(evt_irq)
  );

  exl_stat #(.ID_W(ID_W)) u_stat (
    .clk(clk), .rst(rst), .nxt_run_vld(nxt_run_vld), .nxt_run_idx(nxt_run_idx),
    .nxt_pend_vld(nxt_pend_vld), .nxt_cur_id(nxt_cur_id), .status_q(status)
  );

  AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && (sin_req || sout_req)) |=> !err); // R10
endmodule

// File: tb/exl_sched_tb_top.sv
module exl_sched_tb_top;
  localparam int ID_W = 8;
  localparam int BASE_W = 4;
  localparam int SW = ID_W + 7;

  localparam logic [12:0] DA  = {1'b1, 4'd1, 8'h11};
  localparam logic [12:0] DA2 = {1'b1, 4'd5, 8'h11};
  localparam logic [12:0] DB  = {1'b1, 4'd2, 8'h22};
  localparam logic [12:0] DC  = {1'b1, 4'd3, 8'h33};
  localparam logic [12:0] DN  = 13'd0;

  localparam logic [5:0] F_I2A = 6'h01;
  localparam logic [5:0] F_ESW = 6'h14;
  localparam logic [5:0] F_LP  = 6'h22;
  localparam logic [5:0] F_A2I = 6'h18;

  function automatic logic [14:0] st(input logic cur, input logic wr, input logic l0,
                                     input logic l1, input logic qf, input logic [7:0] id);
    return {id, qf, l1, l1, l0, l0, wr, cur};
  endfunction

  function automatic logic [14:0] ev(input logic [5:0] f, input logic [7:0] id, input logic irq);
    return {f, id, irq};
  endfunction

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  op;
    logic [12:0] c0;
    logic [12:0] c1;
    logic [11:0] fin;
    logic        err;
    logic [1:0]  n;
    logic [14:0] e0;
    logic [14:0] e1;
    logic [14:0] st;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd8,  2'd2, DN, DN, DA[11:0], 1'b1, 2'd0, 15'd0, 15'd0, st(0,0,0,0,0,8'h00)},            // R8 idle out
    '{4'd2,  2'd1, DA, DB, 12'd0,    1'b0, 2'd1, ev(F_I2A,8'h00,1), 15'd0, st(0,1,1,0,0,8'h11)}, // R2
    '{4'd8,  2'd2, DN, DN, DB[11:0], 1'b1, 2'd0, 15'd0, 15'd0, st(0,1,1,0,0,8'h11)},            // R8 not current
    '{4'd1,  2'd2, DN, DN, DA2[11:0],1'b1, 2'd0, 15'd0, 15'd0, st(0,1,1,0,0,8'h11)},            // R1 base differs
    '{4'd6,  2'd2, DN, DN, DA[11:0], 1'b0, 2'd1, ev(F_ESW,8'h11,1), 15'd0, st(0,1,1,0,0,8'h22)}, // R6
    '{4'd3,  2'd1, DB, DC, 12'd0,    1'b0, 2'd1, ev(F_LP,8'h22,1), 15'd0, st(1,0,0,1,0,8'h22)},  // R3 cond one
    '{4'd4,  2'd1, DC, DN, 12'd0,    1'b0, 2'd0, 15'd0, 15'd0, st(1,0,0,1,1,8'h22)},            // R4
    '{4'd5,  2'd1, DA, DN, 12'd0,    1'b1, 2'd0, 15'd0, 15'd0, st(1,0,0,1,1,8'h22)},            // R5
    '{4'd6,  2'd2, DN, DN, DB[11:0], 1'b0, 2'd1, ev(F_ESW,8'h22,1), 15'd0, st(1,0,0,1,1,8'h33)}, // R6
    '{4'd7,  2'd2, DN, DN, DC[11:0], 1'b0, 2'd2, ev(F_A2I,8'h33,0), ev(F_I2A,8'h00,1), st(0,1,1,0,0,8'h33)}, // R7 pending
    '{4'd3,  2'd1, DC, DB, 12'd0,    1'b0, 2'd1, ev(F_LP,8'h33,1), 15'd0, st(1,0,0,1,0,8'h33)},  // R3 cond two
    '{4'd6,  2'd2, DN, DN, DC[11:0], 1'b0, 2'd1, ev(F_ESW,8'h33,1), 15'd0, st(1,0,0,1,0,8'h22)}, // R6
    '{4'd7,  2'd2, DN, DN, DB[11:0], 1'b0, 2'd1, ev(F_A2I,8'h22,1), 15'd0, st(1,0,0,0,0,8'h00)}, // R7 to idle, R9 ptr hold
    '{4'd11, 2'd3, DA, DN, DA[11:0], 1'b1, 2'd0, 15'd0, 15'd0, st(1,0,0,0,0,8'h00)},            // R11
    '{4'd2,  2'd1, DA, DN, 12'd0,    1'b0, 2'd1, ev(F_I2A,8'h00,1), 15'd0, st(0,1,1,0,0,8'h11)}, // R2
    '{4'd4,  2'd1, DB, DN, 12'd0,    1'b0, 2'd0, 15'd0, 15'd0, st(0,1,1,0,1,8'h11)},            // R4
    '{4'd7,  2'd2, DN, DN, DA[11:0], 1'b0, 2'd2, ev(F_A2I,8'h11,0), ev(F_I2A,8'h00,1), st(1,0,0,1,0,8'h22)}  // R7 promote, R9
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sin_req = 1'b0, sin_c0_vld = 1'b0, sin_c1_vld = 1'b0, sout_req = 1'b0;
  logic [ID_W-1:0] sin_c0_id = '0, sin_c1_id = '0, sout_id = '0;
  logic [BASE_W-1:0] sin_c0_base = '0, sin_c1_base = '0, sout_base = '0;
  logic evt_ready = 1'b1;
  logic req_ready, evt_valid, evt_irq, err;
  logic [SW-1:0] status;
  logic [5:0] evt_flags;
  logic [ID_W-1:0] evt_id;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exl_sched #(.ID_W(ID_W), .BASE_W(BASE_W)) dut_i (
    .clk(clk), .rst(rst), .sin_req(sin_req), .sin_c0_id(sin_c0_id),
    .sin_c0_base(sin_c0_base), .sin_c0_vld(sin_c0_vld), .sin_c1_id(sin_c1_id),
    .sin_c1_base(sin_c1_base), .sin_c1_vld(sin_c1_vld), .sout_req(sout_req),
    .sout_id(sout_id), .sout_base(sout_base), .req_ready(req_ready), .status(status),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_flags(evt_flags),
    .evt_id(evt_id), .evt_irq(evt_irq), .err(err)
  );

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [12:0] c0, input logic [12:0] c1,
                       input logic [11:0] fin);
    sin_req = op[0];
    sout_req = op[1];
    {sin_c0_vld, sin_c0_base, sin_c0_id} = c0;
    {sin_c1_vld, sin_c1_base, sin_c1_id} = c1;
    {sout_base, sout_id} = fin;
  endtask

  task automatic run_row(input vec_t v, input int row);
    logic [14:0] got [2];
    int n;
    n = 0;
    got[0] = '0;
    got[1] = '0;
    @(negedge clk);
    drive(v.op, v.c0, v.c1, v.fin);
    @(negedge clk);
    drive(2'b00, DN, DN, 12'd0);
    chk(err == v.err, int'(v.rq), $sformatf("row %0d err", row), 32'(err), 32'(v.err));
    chk(status == v.st, int'(v.rq), $sformatf("row %0d status", row), 32'(status), 32'(v.st));
    for (int k = 0; k < 4; k++) begin
      if (evt_valid) begin
        if (n < 2) got[n] = {evt_flags, evt_id, evt_irq};
        n++;
      end
      @(negedge clk);
    end
    chk(n == int'(v.n), int'(v.rq), $sformatf("row %0d event count", row), 32'(n), 32'(v.n));
    if (v.n >= 2'd1)
      chk(got[0] == v.e0, int'(v.rq), $sformatf("row %0d first event", row), 32'(got[0]), 32'(v.e0));
    if (v.n == 2'd2)
      chk(got[1] == v.e1, int'(v.rq), $sformatf("row %0d second event", row), 32'(got[1]), 32'(v.e1));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R0 watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [ID_W-1:0] held_id;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk(status == '0, 12, "reset status", 32'(status), 0);
    chk(!evt_valid, 12, "reset evt_valid", 32'(evt_valid), 0);
    chk(req_ready, 12, "reset req_ready", 32'(req_ready), 1);
    chk(!err, 12, "reset err", 32'(err), 0);

    for (int i = 0; i < NV; i++) run_row(VEC[i], i);

    // R10 stall: running slot 1 with (B,-), finish B while ready is low
    evt_ready = 1'b0;
    @(negedge clk);
    drive(2'b10, DN, DN, DB[11:0]);
    @(negedge clk);
    drive(2'b01, DA, DN, 12'd0);
    chk(evt_valid, 10, "stall event raised", 32'(evt_valid), 1);
    chk({evt_flags, evt_id, evt_irq} == ev(F_A2I, 8'h22, 1), 7, "idle event",
        32'({evt_flags, evt_id, evt_irq}), 32'(ev(F_A2I, 8'h22, 1)));
    held_id = evt_id;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(evt_valid && evt_id == held_id, 10, "event held while not ready", 32'(evt_id), 32'(held_id));
      chk(!req_ready, 10, "req_ready low while busy", 32'(req_ready), 0);
    end
    drive(2'b00, DN, DN, 12'd0);
    evt_ready = 1'b1;
    @(negedge clk);
    chk(!evt_valid, 10, "single event drained", 32'(evt_valid), 0);
    chk(status == st(1,0,0,0,0,8'h00), 10, "request while busy ignored",
        32'(status), 32'(st(1,0,0,0,0,8'h00)));

    // R12 reset from a running state
    @(negedge clk);
    drive(2'b01, DA, DB, 12'd0);
    @(negedge clk);
    drive(2'b00, DN, DN, 12'd0);
    evt_ready = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(status == '0, 12, "status after reset", 32'(status), 0);
    chk(!evt_valid && req_ready, 12, "event cleared by reset", 32'(evt_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule